// File: doc/BRIEF.md
# UART Interrupt Source Arbiter and Identifier

This block decides which interrupt a 16550-style serial port reports to its host. Five event sources feed it: a receiver line fault (overrun, parity, framing or break), receive data ready at the FIFO threshold, a receive FIFO character timeout, an empty transmit holding register, and a change on a modem control line. Each source has its own enable bit and its own clearing event. The block ranks the enabled, pending sources into four fixed levels. It drives one interrupt line and a 4-bit identification value. That value has a "nothing pending" flag in bit 0 and a 3-bit source code in bits 3:1.

The surrounding port logic supplies one-cycle event pulses, the receive-ready level, FIFO push and pop pulses, a FIFO non-empty level, and a tick once per character time. It also supplies one-cycle strobes for the register accesses that clear sources: reads of line status, receive buffer, identification and modem status, and writes of the transmit holding register. The character-timeout counter is inside this block. The identification value is latched when the identification register is read, so the host always receives a coherent code. All pins are plain control and status signals. There is no streamed data path, so no valid/ready handshake applies.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `irq` is 0 and both `iir_id` and `iir_q` read 4'b0001.
- R2: When several enabled sources are pending, the reported source follows this order: line fault, then receive data, then character timeout, then transmit empty, then modem change. Receive data ranks above the timeout that shares its level.
- R3: `iir_id[3:1]` carries the source code: 011 for line fault, 010 for receive data, 110 for character timeout, 001 for transmit empty, and 000 for modem change. `iir_id[0]` is 0 when a code is reported and 1 when no enabled source is pending, which reads as 4'b0001.
- R4: A `ev_line_err` pulse makes the line fault pending from the next cycle. A `rd_lsr` strobe clears it.
- R5: The receive data source follows the `rx_avail` level without latching and is gated by `ier[0]`.
- R6: In FIFO mode (`fifo_mode`=1) with the FIFO non-empty, the timeout becomes pending after TMO_CHARS `char_tick` pulses (4 by default) with no push, pop or `rd_rbr` in between. Any push, pop, `rd_rbr` or an empty FIFO restarts the count. The timeout is gated by `ier[0]` and is never reported when `fifo_mode`=0.
- R7: A `ev_thr_empty` pulse makes transmit empty pending. A `wr_thr` strobe clears it. A `rd_iir` strobe also clears it, but only in a cycle in which transmit empty is the reported code.
- R8: A `ev_modem` pulse makes the modem source pending. A `rd_msr` strobe clears it.
- R9: Enable bits are `ier[0]` for receive data and timeout, `ier[1]` for transmit empty, `ier[2]` for line fault and `ier[3]` for modem change. A disabled source is never reported. A latched source stays pending while disabled and is reported once it is enabled.
- R10: `irq` is always the inverse of `iir_id[0]`.
- R11: On the clock edge of a `rd_iir` strobe, `iir_q` takes the `iir_id` value of that cycle and holds it until the next `rd_iir`.
- R12: When a source's set pulse and its clearing strobe occur in the same cycle, the source is pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier | input | 4 | Source enables (bit 0 rx/timeout, 1 tx empty, 2 line, 3 modem) |
| fifo_mode | input | 1 | Receive FIFO enabled |
| ev_line_err | input | 1 | Pulse: overrun, parity, framing or break seen |
| rx_avail | input | 1 | Level: receive data ready / threshold reached |
| ev_thr_empty | input | 1 | Pulse: transmit holding register became empty |
| ev_modem | input | 1 | Pulse: change on a modem control input |
| fifo_push | input | 1 | Pulse: character written into receive FIFO |
| fifo_pop | input | 1 | Pulse: character removed from receive FIFO |
| fifo_nonempty | input | 1 | Level: receive FIFO holds at least one character |
| char_tick | input | 1 | Pulse once per character time |
| rd_lsr | input | 1 | Strobe: line status register read |
| rd_rbr | input | 1 | Strobe: receive buffer read |
| rd_iir | input | 1 | Strobe: identification register read |
| rd_msr | input | 1 | Strobe: modem status register read |
| wr_thr | input | 1 | Strobe: transmit holding register write |
| irq | output | 1 | Interrupt request, active high |
| iir_id | output | 4 | Live identification value |
| iir_q | output | 4 | Identification value latched at the last read |

## Verification
Two things can fall in the same cycle: a source's set pulse and the access that clears it. The bench provokes this with a modem change together with a modem status read, and with a transmit-empty event together with a transmit write or an identification read. In each case it expects the source to remain reported afterwards. A second collision is an identification read that both latches the code and clears transmit empty. That case is judged by checking that `iir_q` holds the transmit-empty code while `iir_id` has already moved on to the next source.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned IER_W = 4;
  localparam int unsigned ID_W  = 4;

  localparam int unsigned EN_RX    = 0;
  localparam int unsigned EN_THRE  = 1;
  localparam int unsigned EN_LINE  = 2;
  localparam int unsigned EN_MODEM = 3;

  typedef enum logic [2:0] {
    CODE_MODEM  = 3'b000,
    CODE_THRE   = 3'b001,
    CODE_RXDATA = 3'b010,
    CODE_LINE   = 3'b011,
    CODE_TMO    = 3'b110
  } irq_code_e;

  localparam logic [ID_W-1:0] ID_NONE = 4'b0001;
endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);
  assert_flag_clear_R4_R7_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_o);
endmodule

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo #(
  parameter int unsigned TMO_CHARS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic fifo_push,
  input  logic fifo_pop,
  input  logic fifo_nonempty,
  input  logic rd_rbr,
  input  logic char_tick,
  output logic tmo_hit
);
  localparam int unsigned CNT_W = $clog2(TMO_CHARS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TMO_CHARS);

  logic [CNT_W-1:0] cnt;
  logic restart;

  assign restart = fifo_push | fifo_pop | rd_rbr | !fifo_nonempty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (restart)                  cnt <= '0;
    else if (char_tick && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign tmo_hit = fifo_mode && (cnt == LIMIT);

  assert_tmo_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tmo_hit);
  assert_tmo_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !tmo_hit);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic             line_p,
  input  logic             rx_p,
  input  logic             tmo_p,
  input  logic             thre_p,
  input  logic             modem_p,
  input  logic [IER_W-1:0] ier,
  output logic [ID_W-1:0]  iir_id
);
  always_comb begin
    iir_id = ID_NONE;
    if (line_p && ier[EN_LINE])        iir_id = {CODE_LINE,   1'b0};
    else if (rx_p && ier[EN_RX])       iir_id = {CODE_RXDATA, 1'b0};
    else if (tmo_p && ier[EN_RX])      iir_id = {CODE_TMO,    1'b0};
    else if (thre_p && ier[EN_THRE])   iir_id = {CODE_THRE,   1'b0};
    else if (modem_p && ier[EN_MODEM]) iir_id = {CODE_MODEM,  1'b0};
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned TMO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IER_W-1:0] ier,
  input  logic             fifo_mode,
  input  logic             ev_line_err,
  input  logic             rx_avail,
  input  logic             ev_thr_empty,
  input  logic             ev_modem,
  input  logic             fifo_push,
  input  logic             fifo_pop,
  input  logic             fifo_nonempty,
  input  logic             char_tick,
  input  logic             rd_lsr,
  input  logic             rd_rbr,
  input  logic             rd_iir,
  input  logic             rd_msr,
  input  logic             wr_thr,
  output logic             irq,
  output logic [ID_W-1:0]  iir_id,
  output logic [ID_W-1:0]  iir_q
);
  localparam int unsigned NFLAG = 3;

  logic [NFLAG-1:0] f_set, f_clr, f_pend;
  logic line_p, thre_p, modem_p, tmo_p, thre_shown;

  assign thre_shown = (iir_id == {CODE_THRE, 1'b0});

  assign f_set = {ev_modem, ev_thr_empty, ev_line_err};
  assign f_clr = {rd_msr, wr_thr | (rd_iir & thre_shown), rd_lsr};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    uart_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (f_set[g]),
      .clr_i  (f_clr[g]),
      .pend_o (f_pend[g])
    );
  end

  assign line_p  = f_pend[0];
  assign thre_p  = f_pend[1];
  assign modem_p = f_pend[2];

  uart_irq_tmo #(.TMO_CHARS(TMO_CHARS)) u_tmo (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_mode     (fifo_mode),
    .fifo_push     (fifo_push),
    .fifo_pop      (fifo_pop),
    .fifo_nonempty (fifo_nonempty),
    .rd_rbr        (rd_rbr),
    .char_tick     (char_tick),
    .tmo_hit       (tmo_p)
  );

  uart_irq_prio u_prio (
    .line_p  (line_p),
    .rx_p    (rx_avail),
    .tmo_p   (tmo_p),
    .thre_p  (thre_p),
    .modem_p (modem_p),
    .ier     (ier),
    .iir_id  (iir_id)
  );

  assign irq = !iir_id[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      iir_q <= ID_NONE;
    else if (rd_iir) iir_q <= iir_id;
  end

  assert_iir_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_iir |=> iir_q == $past(iir_id));
  assert_thre_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && thre_shown && !ev_thr_empty && !wr_thr) |=> !thre_p);
  assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_p && ier[EN_LINE]) |-> iir_id == {CODE_LINE, 1'b0});
  assert_line_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ier[EN_LINE] |-> iir_id != {CODE_LINE, 1'b0});
endmodule

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] ier = '0;
  logic fifo_mode = 0, ev_line_err = 0, rx_avail = 0, ev_thr_empty = 0, ev_modem = 0;
  logic fifo_push = 0, fifo_pop = 0, fifo_nonempty = 0, char_tick = 0;
  logic rd_lsr = 0, rd_rbr = 0, rd_iir = 0, rd_msr = 0, wr_thr = 0;
  logic irq;
  logic [3:0] iir_id, iir_q;

  localparam logic [3:0] NONE = 4'b0001, LINE = 4'b0110, RXD = 4'b0100,
                         TMO = 4'b1100, THRE = 4'b0010, MODEM = 4'b0000;

  typedef struct { logic [3:0] id; logic [3:0] q; string tag; } item_t;
  item_t sb[$];
  int checks = 0, errors = 0, cycles = 0;
  logic [3:0] last_id = 4'b0001, exp_q = 4'b0001;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rst_n(rst_n), .ier(ier), .fifo_mode(fifo_mode),
    .ev_line_err(ev_line_err), .rx_avail(rx_avail), .ev_thr_empty(ev_thr_empty),
    .ev_modem(ev_modem), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
    .fifo_nonempty(fifo_nonempty), .char_tick(char_tick), .rd_lsr(rd_lsr),
    .rd_rbr(rd_rbr), .rd_iir(rd_iir), .rd_msr(rd_msr), .wr_thr(wr_thr),
    .irq(irq), .iir_id(iir_id), .iir_q(iir_q)
  );

  // Driver: inputs set at a falling edge; expected state after the next rising edge.
  task automatic exp(input logic [3:0] id, input string tag);
    item_t it;
    if (rd_iir) exp_q = last_id;
    it.id = id; it.q = exp_q; it.tag = tag;
    sb.push_back(it);
    last_id = id;
    @(negedge clk);
    ev_line_err = 0; ev_thr_empty = 0; ev_modem = 0; fifo_push = 0; fifo_pop = 0;
    char_tick = 0; rd_lsr = 0; rd_rbr = 0; rd_iir = 0; rd_msr = 0; wr_thr = 0;
  endtask

  task automatic ticks(input int n, input logic [3:0] last, input string tag);
    for (int i = 0; i < n; i++) begin
      char_tick = 1;
      exp((i == n - 1) ? last : NONE, tag);
    end
  endtask

  // Monitor: pops the scoreboard just after each rising edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (iir_id !== it.id) begin
        errors++; $display("FAIL %s: iir_id=%b expected %b", it.tag, iir_id, it.id);
      end
      if (iir_q !== it.q) begin
        errors++; $display("FAIL R11 (%s): iir_q=%b expected %b", it.tag, iir_q, it.q);
      end
      if (irq !== !it.id[0]) begin
        errors++; $display("FAIL R10 (%s): irq=%b expected %b", it.tag, irq, !it.id[0]);
      end
    end
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog: cycles=%0d expected < 20000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    exp(NONE, "R1"); exp(NONE, "R1");
    // priority ladder
    ier = 4'hF; ev_modem = 1;   exp(MODEM, "R8");
    ev_thr_empty = 1;           exp(THRE, "R2");
    rx_avail = 1;               exp(RXD, "R5");
    ev_line_err = 1;            exp(LINE, "R4");
    rd_iir = 1;                 exp(LINE, "R11");
    rd_lsr = 1;                 exp(RXD, "R4");
    rx_avail = 0;               exp(THRE, "R5");
    rd_iir = 1;                 exp(MODEM, "R7");
    rd_msr = 1;                 exp(NONE, "R8");
    // identification read while transmit empty is not reported
    ier = 4'b0110; ev_thr_empty = 1; ev_line_err = 1; exp(LINE, "R3");
    rd_iir = 1;                 exp(LINE, "R7");
    rd_lsr = 1;                 exp(THRE, "R7");
    wr_thr = 1;                 exp(NONE, "R7");
    // masking
    ier = 4'b0000; ev_line_err = 1; ev_modem = 1; ev_thr_empty = 1; rx_avail = 1;
                                exp(NONE, "R9");
    ier = 4'b1000;              exp(MODEM, "R9");
    ier = 4'b1100;              exp(LINE, "R9");
    ier = 4'b1111; rd_lsr = 1;  exp(RXD, "R9");
    rx_avail = 0;               exp(THRE, "R2");
    wr_thr = 1;                 exp(MODEM, "R7");
    rd_msr = 1;                 exp(NONE, "R8");
    // same-cycle set and clear
    ier = 4'b1000; ev_modem = 1; exp(MODEM, "R12");
    ev_modem = 1; rd_msr = 1;   exp(MODEM, "R12");
    rd_msr = 1;                 exp(NONE, "R12");
    ier = 4'b0010; ev_thr_empty = 1; wr_thr = 1; exp(THRE, "R12");
    ev_thr_empty = 1; rd_iir = 1; exp(THRE, "R12");
    wr_thr = 1;                 exp(NONE, "R7");
    // character timeout
    ier = 4'b0001; fifo_mode = 1; fifo_nonempty = 1; fifo_push = 1; exp(NONE, "R6");
    ticks(4, TMO, "R6");
    rx_avail = 1;               exp(RXD, "R2");
    rx_avail = 0;               exp(TMO, "R3");
    rd_iir = 1;                 exp(TMO, "R11");
    fifo_pop = 1;               exp(NONE, "R6");
    ticks(3, NONE, "R6");
    fifo_push = 1;              exp(NONE, "R6");
    ticks(3, NONE, "R6");
    ticks(1, TMO, "R6");
    rd_rbr = 1;                 exp(NONE, "R6");
    ier = 4'b0000;
    ticks(4, NONE, "R6");
    ier = 4'b0001;              exp(TMO, "R9");
    rd_rbr = 1;                 exp(NONE, "R6");
    fifo_mode = 0;
    ticks(5, NONE, "R6");
    fifo_nonempty = 0;          exp(NONE, "R6");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule